// File: doc/BRIEF.md
# Synchronous Cache SRAM Access Controller

This block is the clocked control path of a 32-bit cache SRAM whose data bus is shared between reads and writes. On every rising clock edge it decides whether a new access starts, whether a running burst steps forward, holds or stops, and which byte lanes of the storage array are written. Two address strobes compete for the start of an access: a processor-side strobe and a controller-side strobe. Three chip selects qualify both of them, and the first select also hides the processor strobe completely.

A started access loads the presented address into an address register. The two low address bits seed a four-beat wraparound burst. Each later cycle with the advance input low steps the burst in linear or interleaved order, chosen by a mode pin. Reads are flow-through: the word at the registered address appears on the read bus in the same cycle the address is registered. A combinational drive enable tells the pad ring when to drive the shared bus. It is gated by the asynchronous output enable, and it is forced off whenever the write inputs ask for a write.

The storage is a behavioural per-lane register array inside the block. Pad drivers, electrical timing and low-power modes are outside its scope.

Top module: `csram_ctrl`

## Requirements
- R1: When either strobe starts a qualified request but the three selects are not all active (sel_a_n low, sel_b high, sel_c_n low), the block is deselected. From the next cycle on, dq_drive stays low until a new access starts.
- R2: If both strobes are low and all selects are active, the processor strobe wins. The access starts at addr_in, and byte_we is 0 in that cycle whatever the write inputs say.
- R3: With sel_a_n high, a low processor strobe has no effect. A running burst keeps its address and its data unless other inputs change them.
- R4: A controller-strobe access (ctrl_strb_n low, proc_strb_n high, all selects active) loads addr_in into cur_addr. If a write is requested, it writes dq_in at addr_in on that same edge.
- R5: Bit i of byte_we and of lane_sel_n governs data bits [8i+7:8i]. Lane 0 is bits [7:0] and lane 3 is bits [31:24].
- R6: all_wr_n low requests all four lanes. Otherwise lane_wr_en_n low requests each lane whose lane_sel_n bit is 0. If neither applies, the cycle is a read. Requests become byte_we only during a controller-strobe start or in a running burst with no new strobe.
- R7: While any lane write is requested, dq_drive is 0 whatever oe_n is.
- R8: dq_drive is 1 only while an access is active, oe_n is low and no write is requested. oe_n acts combinationally, with no clock.
- R9: With ilv_mode 0 the burst is linear. Beat k has low address bits (s + k) mod 4, where s is the low two bits of the loaded address. The upper bits never change.
- R10: With ilv_mode 1 the burst is interleaved. Beat k has low address bits s XOR k.
- R11: In a running burst with no strobe, adv_n high holds cur_addr. adv_n low steps to the next beat, wrapping after the fourth beat.
- R12: A qualified strobe during a running burst abandons it and restarts the burst at the new addr_in.
- R13: Flow-through read: in the cycle after the edge that registers an address, dq_out holds the stored word at cur_addr, including bytes written on that edge.
- R14: After reset no access is active, dq_drive is 0 and cur_addr is 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous active-low reset |
| addr_in | input | ADDR_W | Address presented with a strobe |
| proc_strb_n | input | 1 | Processor-side address strobe, active low |
| ctrl_strb_n | input | 1 | Controller-side address strobe, active low |
| adv_n | input | 1 | Burst advance, active low |
| sel_a_n | input | 1 | Chip select A, active low, also masks the processor strobe |
| sel_b | input | 1 | Chip select B, active high |
| sel_c_n | input | 1 | Chip select C, active low |
| all_wr_n | input | 1 | Write all lanes, active low |
| lane_wr_en_n | input | 1 | Per-lane write enable, active low |
| lane_sel_n | input | LANES | Per-lane write select, active low |
| oe_n | input | 1 | Asynchronous output enable, active low |
| ilv_mode | input | 1 | Burst order: 1 interleaved, 0 linear |
| dq_in | input | 8*LANES | Write data from the shared bus |
| dq_out | output | 8*LANES | Flow-through read data |
| dq_drive | output | 1 | Enable for the shared-bus drivers |
| cur_addr | output | ADDR_W | Registered address of the current beat |
| byte_we | output | LANES | Lane write enables applied at the coming edge |

## Verification
The contested cycle is a strobe arriving while a write request is present on the same edge. Its outcome depends on which strobe wins and on whether select A masks the processor strobe. The bench provokes it both ways. Random stimulus drives both strobes, the selects and the write inputs independently, so all of these coincide often; directed cases place both strobes low together with a full-word write, and a masked processor strobe in the middle of a burst. Each cycle is judged by checking byte_we before the edge against a bench model (zero on a processor start, the decoded lanes otherwise). After the edge, cur_addr and the flow-through data are compared with the model's memory image.

// File: rtl/csram_pkg.sv
package csram_pkg;

   // Per-edge decision taken from the strobes and the selects
   typedef enum logic [1:0] {
      ACC_NONE  = 2'd0,
      ACC_PROC  = 2'd1,
      ACC_CTRL  = 2'd2,
      ACC_DESEL = 2'd3
   } acc_e;

   localparam int unsigned BEAT_W = 2;

   // Low address bits of beat k of a burst seeded with s
   function automatic logic [BEAT_W-1:0] beat_lo(
      input logic [BEAT_W-1:0] s,
      input logic [BEAT_W-1:0] k,
      input logic              ilv
   );
      return ilv ? (s ^ k) : (s + k);
   endfunction

endpackage

// File: rtl/csram_strobe.sv
module csram_strobe
   import csram_pkg::*;
(
   input  logic proc_strb_n,
   input  logic ctrl_strb_n,
   input  logic sel_a_n,
   input  logic sel_b,
   input  logic sel_c_n,
   output acc_e acc
);
   logic all_sel;
   logic proc_seen;

   assign all_sel   = ~sel_a_n & sel_b & ~sel_c_n;
   // select A hides the processor strobe entirely
   assign proc_seen = ~proc_strb_n & ~sel_a_n;

   always_comb begin
      if (all_sel && !proc_strb_n)
         acc = ACC_PROC;
      else if (all_sel && !ctrl_strb_n)
         acc = ACC_CTRL;
      else if (!ctrl_strb_n || proc_seen)
         acc = ACC_DESEL;
      else
         acc = ACC_NONE;
   end
endmodule

// File: rtl/csram_burst.sv
module csram_burst
   import csram_pkg::*;
#(
   parameter int unsigned ADDR_W = 8
) (
   input  logic              clk,
   input  logic              rst_n,
   input  acc_e              acc,
   input  logic              adv_n,
   input  logic              ilv_mode,
   input  logic [ADDR_W-1:0] addr_in,
   output logic              act,
   output logic [ADDR_W-1:0] cur_addr,
   output logic [ADDR_W-1:0] nxt_addr,
   output logic              wr_ok
);
   localparam int unsigned HI_W = ADDR_W - BEAT_W;

   logic              act_q, act_d;
   logic [ADDR_W-1:0] base_q, base_d;
   logic [BEAT_W-1:0] k_q, k_d;

   assign cur_addr = {base_q[ADDR_W-1:BEAT_W], beat_lo(base_q[BEAT_W-1:0], k_q, ilv_mode)};
   assign act      = act_q;
   assign wr_ok    = (acc == ACC_CTRL) || ((acc == ACC_NONE) && act_q);

   always_comb begin
      act_d    = act_q;
      base_d   = base_q;
      k_d      = k_q;
      nxt_addr = cur_addr;
      unique case (acc)
         ACC_PROC, ACC_CTRL: begin
            act_d    = 1'b1;
            base_d   = addr_in;
            k_d      = '0;
            nxt_addr = addr_in;
         end
         ACC_DESEL: begin
            act_d = 1'b0;
         end
         default: begin
            if (act_q && !adv_n) begin
               k_d      = k_q + 1'b1;
               nxt_addr = {base_q[ADDR_W-1:BEAT_W],
                           beat_lo(base_q[BEAT_W-1:0], k_d, ilv_mode)};
            end
         end
      endcase
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         act_q  <= 1'b0;
         base_q <= '0;
         k_q    <= '0;
      end else begin
         act_q  <= act_d;
         base_q <= base_d;
         k_q    <= k_d;
      end
   end

   logic [HI_W-1:0] unused_hi;
   assign unused_hi = base_q[ADDR_W-1:BEAT_W];
endmodule

// File: rtl/csram_bytewr.sv
module csram_bytewr #(
   parameter int unsigned LANES = 4
) (
   input  logic             all_wr_n,
   input  logic             lane_wr_en_n,
   input  logic [LANES-1:0] lane_sel_n,
   input  logic             wr_ok,
   output logic [LANES-1:0] lane_req,
   output logic [LANES-1:0] lane_we
);
   for (genvar i = 0; i < LANES; i++) begin : g_lane
      assign lane_req[i] = ~all_wr_n | (~lane_wr_en_n & ~lane_sel_n[i]);
      assign lane_we[i]  = lane_req[i] & wr_ok;
   end
endmodule

// File: rtl/csram_array.sv
module csram_array #(
   parameter int unsigned ADDR_W = 8,
   parameter int unsigned LANES  = 4
) (
   input  logic                 clk,
   input  logic [LANES-1:0]     we,
   input  logic [ADDR_W-1:0]    waddr,
   input  logic [8*LANES-1:0]   wdata,
   input  logic [ADDR_W-1:0]    raddr,
   output logic [8*LANES-1:0]   rdata
);
   localparam int unsigned DEPTH = 1 << ADDR_W;

   for (genvar i = 0; i < LANES; i++) begin : g_lane
      logic [7:0] mem [DEPTH];
      always_ff @(posedge clk) begin
         if (we[i]) mem[waddr] <= wdata[8*i +: 8];
      end
      assign rdata[8*i +: 8] = mem[raddr];
   end
endmodule

// File: rtl/csram_ctrl.sv
module csram_ctrl
   import csram_pkg::*;
#(
   parameter int unsigned ADDR_W = 8,
   parameter int unsigned LANES  = 4
) (
   input  logic                 clk,
   input  logic                 rst_n,
   input  logic [ADDR_W-1:0]    addr_in,
   input  logic                 proc_strb_n,
   input  logic                 ctrl_strb_n,
   input  logic                 adv_n,
   input  logic                 sel_a_n,
   input  logic                 sel_b,
   input  logic                 sel_c_n,
   input  logic                 all_wr_n,
   input  logic                 lane_wr_en_n,
   input  logic [LANES-1:0]     lane_sel_n,
   input  logic                 oe_n,
   input  logic                 ilv_mode,
   input  logic [8*LANES-1:0]   dq_in,
   output logic [8*LANES-1:0]   dq_out,
   output logic                 dq_drive,
   output logic [ADDR_W-1:0]    cur_addr,
   output logic [LANES-1:0]     byte_we
);
   localparam int unsigned DATA_W = 8 * LANES;

   if (ADDR_W <= BEAT_W) begin : g_bad_addr
      $error("csram_ctrl: ADDR_W must exceed the burst field width");
   end
   if (LANES < 1 || LANES > 16) begin : g_bad_lanes
      $error("csram_ctrl: LANES out of range");
   end

   acc_e              acc;
   logic              act_q;
   logic              wr_ok;
   logic [ADDR_W-1:0] nxt_addr;
   logic [LANES-1:0]  lane_req;
   logic [DATA_W-1:0] rd_word;

   csram_strobe u_strobe (
      .proc_strb_n (proc_strb_n),
      .ctrl_strb_n (ctrl_strb_n),
      .sel_a_n     (sel_a_n),
      .sel_b       (sel_b),
      .sel_c_n     (sel_c_n),
      .acc         (acc)
   );

   csram_burst #(.ADDR_W(ADDR_W)) u_burst (
      .clk      (clk),
      .rst_n    (rst_n),
      .acc      (acc),
      .adv_n    (adv_n),
      .ilv_mode (ilv_mode),
      .addr_in  (addr_in),
      .act      (act_q),
      .cur_addr (cur_addr),
      .nxt_addr (nxt_addr),
      .wr_ok    (wr_ok)
   );

   csram_bytewr #(.LANES(LANES)) u_bytewr (
      .all_wr_n     (all_wr_n),
      .lane_wr_en_n (lane_wr_en_n),
      .lane_sel_n   (lane_sel_n),
      .wr_ok        (wr_ok),
      .lane_req     (lane_req),
      .lane_we      (byte_we)
   );

   csram_array #(.ADDR_W(ADDR_W), .LANES(LANES)) u_array (
      .clk   (clk),
      .we    (byte_we),
      .waddr (nxt_addr),
      .wdata (dq_in),
      .raddr (cur_addr),
      .rdata (rd_word)
   );

   assign dq_out   = rd_word;
   // any write request turns the bus drivers off, whatever oe_n says
   assign dq_drive = act_q & ~oe_n & ~(|lane_req);
endmodule

// File: rtl/csram_ctrl_chk.sv
module csram_ctrl_chk #(
   parameter int unsigned ADDR_W = 8,
   parameter int unsigned LANES  = 4
) (
   input logic              clk,
   input logic              rst_n,
   input logic [ADDR_W-1:0] addr_in,
   input logic              proc_strb_n,
   input logic              ctrl_strb_n,
   input logic              adv_n,
   input logic              sel_a_n,
   input logic              sel_b,
   input logic              sel_c_n,
   input logic              all_wr_n,
   input logic              lane_wr_en_n,
   input logic [LANES-1:0]  lane_sel_n,
   input logic              oe_n,
   input logic              ilv_mode,
   input logic              dq_drive,
   input logic [ADDR_W-1:0] cur_addr,
   input logic [LANES-1:0]  byte_we,
   input logic              act
);
   logic all_sel;
   logic wr_req;
   assign all_sel = ~sel_a_n & sel_b & ~sel_c_n;
   assign wr_req  = ~all_wr_n | (~lane_wr_en_n & (lane_sel_n != '1));

   // R7
   wr_hiz_chk: assert property (@(posedge clk) disable iff (!rst_n)
      wr_req |-> !dq_drive);

   // R8
   oe_gate_chk: assert property (@(posedge clk) disable iff (!rst_n)
      oe_n |-> !dq_drive);

   // R2
   proc_rd_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (all_sel && !proc_strb_n) |-> (byte_we == '0));

   // R4
   ctrl_load_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (all_sel && !ctrl_strb_n && proc_strb_n) |=> (cur_addr == $past(addr_in)));

   // R3
   proc_mask_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (act && sel_a_n && !proc_strb_n && ctrl_strb_n && adv_n)
      |=> ($stable(cur_addr) || (ilv_mode != $past(ilv_mode))));

   // R11
   suspend_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (act && proc_strb_n && ctrl_strb_n && adv_n)
      |=> ($stable(cur_addr) || (ilv_mode != $past(ilv_mode))));

   // R1
   desel_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (!all_sel && !ctrl_strb_n) |=> (!act && !dq_drive));
endmodule

bind csram_ctrl csram_ctrl_chk #(.ADDR_W(ADDR_W), .LANES(LANES)) u_chk (
   .clk          (clk),
   .rst_n        (rst_n),
   .addr_in      (addr_in),
   .proc_strb_n  (proc_strb_n),
   .ctrl_strb_n  (ctrl_strb_n),
   .adv_n        (adv_n),
   .sel_a_n      (sel_a_n),
   .sel_b        (sel_b),
   .sel_c_n      (sel_c_n),
   .all_wr_n     (all_wr_n),
   .lane_wr_en_n (lane_wr_en_n),
   .lane_sel_n   (lane_sel_n),
   .oe_n         (oe_n),
   .ilv_mode     (ilv_mode),
   .dq_drive     (dq_drive),
   .cur_addr     (cur_addr),
   .byte_we      (byte_we),
   .act          (act_q)
);

// File: tb/csram_ctrl_bench.sv
module csram_ctrl_bench;
   localparam int CLK_P = 10;
   localparam int AW    = 8;
   localparam int LN    = 4;

   logic          clk = 1'b0;
   logic          rst_n = 1'b0;
   logic [AW-1:0] addr_in = '0;
   logic          proc_strb_n = 1'b1, ctrl_strb_n = 1'b1, adv_n = 1'b1;
   logic          sel_a_n = 1'b0, sel_b = 1'b1, sel_c_n = 1'b0;
   logic          all_wr_n = 1'b1, lane_wr_en_n = 1'b1;
   logic [LN-1:0] lane_sel_n = '1;
   logic          oe_n = 1'b0, ilv_mode = 1'b0;
   logic [31:0]   dq_in = '0;
   logic [31:0]   dq_out;
   logic          dq_drive;
   logic [AW-1:0] cur_addr;
   logic [LN-1:0] byte_we;

   csram_ctrl #(.ADDR_W(AW), .LANES(LN)) u_csram_ctrl (
      .clk(clk), .rst_n(rst_n), .addr_in(addr_in),
      .proc_strb_n(proc_strb_n), .ctrl_strb_n(ctrl_strb_n), .adv_n(adv_n),
      .sel_a_n(sel_a_n), .sel_b(sel_b), .sel_c_n(sel_c_n),
      .all_wr_n(all_wr_n), .lane_wr_en_n(lane_wr_en_n), .lane_sel_n(lane_sel_n),
      .oe_n(oe_n), .ilv_mode(ilv_mode), .dq_in(dq_in),
      .dq_out(dq_out), .dq_drive(dq_drive), .cur_addr(cur_addr), .byte_we(byte_we)
   );

   always #(CLK_P/2) clk = ~clk;

   int nchk = 0;
   int nfail = 0;
   bit done = 1'b0;

   // bench model
   logic          m_act = 1'b0;
   logic [AW-1:0] m_base = '0;
   logic [1:0]    m_k = '0;
   logic [31:0]   m_mem [1<<AW];

   task automatic chk(input logic ok, input string tag, input logic [31:0] got, input logic [31:0] exp);
      nchk++;
      if (!ok) begin
         nfail++;
         $display("FAIL %s: actual %h expected %h at %0t", tag, got, exp, $time);
      end
   endtask

   function automatic logic [1:0] f_lo(input logic [1:0] s, input logic [1:0] k, input logic ilv);
      return ilv ? (s ^ k) : (s + k);
   endfunction

   function automatic logic [AW-1:0] f_cur();
      return {m_base[AW-1:2], f_lo(m_base[1:0], m_k, ilv_mode)};
   endfunction

   // 0 none, 1 processor start, 2 controller start, 3 deselect
   function automatic int f_acc();
      logic all_sel;
      all_sel = !sel_a_n && sel_b && !sel_c_n;
      if (all_sel && !proc_strb_n) return 1;
      if (all_sel && !ctrl_strb_n) return 2;
      if (!ctrl_strb_n || (!proc_strb_n && !sel_a_n)) return 3;
      return 0;
   endfunction

   function automatic logic [LN-1:0] f_req();
      if (!all_wr_n) return '1;
      if (!lane_wr_en_n) return ~lane_sel_n;
      return '0;
   endfunction

   task automatic set_idle();
      proc_strb_n = 1'b1; ctrl_strb_n = 1'b1; adv_n = 1'b1;
      sel_a_n = 1'b0; sel_b = 1'b1; sel_c_n = 1'b0;
      all_wr_n = 1'b1; lane_wr_en_n = 1'b1; lane_sel_n = '1; oe_n = 1'b0;
   endtask

   // called at a falling edge with inputs set; returns at the next falling edge
   task automatic cyc();
      int            acc;
      logic          wrok;
      logic [LN-1:0] req, we;
      logic [AW-1:0] ea;
      #1;
      acc  = f_acc();
      req  = f_req();
      wrok = (acc == 2) || (acc == 0 && m_act);
      we   = wrok ? req : '0;
      chk(byte_we == we, "R2/R4/R5/R6 byte_we", 32'(byte_we), 32'(we));
      chk(dq_drive == (m_act && !oe_n && req == '0), "R1/R7/R8 dq_drive",
          32'(dq_drive), 32'(m_act && !oe_n && req == '0));
      @(posedge clk);
      ea = f_cur();
      if (acc == 1 || acc == 2) begin
         m_act = 1'b1; m_base = addr_in; m_k = '0; ea = addr_in;
      end else if (acc == 3) begin
         m_act = 1'b0;
      end else if (m_act && !adv_n) begin
         m_k = m_k + 2'd1; ea = f_cur();
      end
      for (int i = 0; i < LN; i++)
         if (we[i]) m_mem[ea][8*i +: 8] = dq_in[8*i +: 8];
      @(negedge clk);
      chk(cur_addr == f_cur(), "R3/R9/R10/R11/R12 cur_addr", 32'(cur_addr), 32'(f_cur()));
      if (m_act)
         chk(dq_out == m_mem[cur_addr], "R13 dq_out", dq_out, m_mem[cur_addr]);
   endtask

   initial begin
      #(CLK_P * 200000);
      if (!done) begin
         nchk++; nfail++;
         $display("FAIL watchdog: actual hung expected finish");
         $display("== %0d vectors applied, %0d miscompares ==", nchk, nfail);
         $finish;
      end
   end

   initial begin
      void'($urandom(32'h5eed_0123));
      repeat (3) @(negedge clk);
      // R14 reset state
      chk(dq_drive == 1'b0, "R14 reset dq_drive", 32'(dq_drive), 32'd0);
      chk(cur_addr == '0, "R14 reset cur_addr", 32'(cur_addr), 32'd0);
      rst_n = 1'b1;
      @(negedge clk);
      chk(dq_drive == 1'b0, "R14 idle dq_drive", 32'(dq_drive), 32'd0);

      // fill every word through controller-strobe full writes (R4)
      for (int a = 0; a < (1 << AW); a++) begin
         set_idle(); ctrl_strb_n = 1'b0; all_wr_n = 1'b0;
         addr_in = AW'(a); dq_in = 32'(a) * 32'h0101_0107 ^ 32'hA5C3_0F1E;
         cyc();
      end

      // R5: lane 2 only
      set_idle(); ctrl_strb_n = 1'b0; lane_wr_en_n = 1'b0; lane_sel_n = 4'b1011;
      addr_in = 8'h10; dq_in = 32'h1122_3344;
      cyc();
      set_idle(); cyc();
      chk(dq_out[23:16] == 8'h22, "R5 lane2 byte", 32'(dq_out[23:16]), 32'h22);
      chk(dq_drive == 1'b1, "R8 read drive", 32'(dq_drive), 32'd1);

      // R2: both strobes with a full write: processor start, no write
      set_idle(); proc_strb_n = 1'b0; ctrl_strb_n = 1'b0; all_wr_n = 1'b0;
      addr_in = 8'h20; dq_in = 32'hDEAD_BEEF;
      cyc();
      set_idle(); cyc();
      chk(dq_out != 32'hDEAD_BEEF, "R2 no write on processor start", dq_out, m_mem[8'h20]);

      // R9 linear from 0x31: 32,33,30 then wrap to 31
      ilv_mode = 1'b0;
      set_idle(); proc_strb_n = 1'b0; addr_in = 8'h31; cyc();
      set_idle(); adv_n = 1'b0; cyc();
      chk(cur_addr == 8'h32, "R9 linear beat1", 32'(cur_addr), 32'h32);
      cyc(); chk(cur_addr == 8'h33, "R9 linear beat2", 32'(cur_addr), 32'h33);
      cyc(); chk(cur_addr == 8'h30, "R9 linear beat3", 32'(cur_addr), 32'h30);
      cyc(); chk(cur_addr == 8'h31, "R11 wrap", 32'(cur_addr), 32'h31);

      // R10 interleaved from 0x31: 30,33,32
      ilv_mode = 1'b1;
      set_idle(); ctrl_strb_n = 1'b0; addr_in = 8'h31; cyc();
      set_idle(); adv_n = 1'b0; cyc();
      chk(cur_addr == 8'h30, "R10 ilv beat1", 32'(cur_addr), 32'h30);
      cyc(); chk(cur_addr == 8'h33, "R10 ilv beat2", 32'(cur_addr), 32'h33);
      // R11 hold
      set_idle(); cyc();
      chk(cur_addr == 8'h33, "R11 suspend", 32'(cur_addr), 32'h33);
      // R3 masked processor strobe
      set_idle(); sel_a_n = 1'b1; proc_strb_n = 1'b0; addr_in = 8'h77; cyc();
      chk(cur_addr == 8'h33, "R3 masked strobe", 32'(cur_addr), 32'h33);
      // R12 restart mid burst
      set_idle(); ctrl_strb_n = 1'b0; addr_in = 8'h42; cyc();
      chk(cur_addr == 8'h42, "R12 restart", 32'(cur_addr), 32'h42);
      // R7 write with oe low
      set_idle(); lane_wr_en_n = 1'b0; lane_sel_n = 4'b1110; dq_in = 32'h0000_00AB;
      #1; chk(dq_drive == 1'b0, "R7 write hiz", 32'(dq_drive), 32'd0);
      cyc();
      // R1 deselect via select B
      set_idle(); sel_b = 1'b0; ctrl_strb_n = 1'b0; cyc();
      set_idle(); #1;
      chk(dq_drive == 1'b0, "R1 deselected", 32'(dq_drive), 32'd0);
      cyc();

      // random phase
      for (int blk = 0; blk < 8; blk++) begin
         ilv_mode = blk[0];
         for (int n = 0; n < 500; n++) begin
            proc_strb_n  = ($urandom % 100) >= 12;
            ctrl_strb_n  = ($urandom % 100) >= 15;
            adv_n        = ($urandom % 100) >= 60;
            sel_a_n      = ($urandom % 100) >= 85;
            sel_b        = ($urandom % 100) < 92;
            sel_c_n      = ($urandom % 100) >= 92;
            all_wr_n     = ($urandom % 100) >= 10;
            lane_wr_en_n = ($urandom % 100) >= 30;
            lane_sel_n   = LN'($urandom);
            oe_n         = ($urandom % 100) >= 80;
            addr_in      = AW'($urandom);
            dq_in        = $urandom;
            cyc();
         end
      end

      done = 1'b1;
      $display("== %0d vectors applied, %0d miscompares ==", nchk, nfail);
      $finish;
   end
endmodule